// File: doc/BRIEF.md
# Streaming Instruction Fetch Queue

This block sits between a processor core and a shared memory that grants access in turn. Once the core names a branch target, the block reads 32-bit words in order from that target. When the memory grants every cycle, it reads one word per clock. It hands whole 32-bit instructions to the core over a valid/ready handshake. Operand reads and result writes never pass through it: they use the core's local registers, so this queue carries only the instruction stream.

Targets are byte addresses, so an instruction may begin at any byte. When the start is not on a word boundary, each instruction is taken from the upper bytes of one buffered word and the lower bytes of the next. Every branch empties the buffer and restarts fetching, even when the target is close behind the current address. Responses that were already requested before a branch are recognised by a one-bit epoch tag and by an in-order count of the requests still pending, and they are dropped. The core stalls until the new words arrive. After that it runs at one instruction per clock until the next branch.

The memory is assumed to answer requests in the order they were granted, after any number of cycles. The buffer depth must be a power of two.

Top module: `ifq_stream_fetch`

## Requirements
- R1: After reset and before the first branch, `ins_valid` and `mem_req` stay low.
- R2: After a branch to byte address A, the granted requests carry word addresses A>>2, A>>2+1, A>>2+2 and so on, with no gaps, counted from the first request after the branch.
- R3: With a grant and a ready core every cycle, the block issues a request in each of the first DEPTH cycles after the branch cycle. Once the first instruction is valid, a new instruction is valid in every cycle until the next branch.
- R4: The words held plus the requests pending never exceed DEPTH. With the core stalled, exactly DEPTH requests are issued after a branch. Each instruction the core accepts allows exactly one more request.
- R5: Memory is little-endian: the byte at address b is bits [8*(b mod 4)+7 : 8*(b mod 4)] of the word at b>>2. The delivered instruction at `ins_pc` = P is built from bytes P..P+3, with byte P in bits [7:0]. `ins_pc` starts at the branch target and advances by 4 for each accepted instruction.
- R6: The first instruction after a branch is not valid until its words are buffered. A target with low two bits 00 needs one word. Any other target needs two words.
- R7: A response to a request granted before a branch is never delivered, including a response that arrives in the branch cycle itself.
- R8: In a cycle where `br_valid` is high, `ins_valid` and `mem_req` are both low. No handshake and no request complete in that cycle.
- R9: A branch to an address whose word is already buffered still produces fresh requests from the target word, beginning in the cycle after the branch.
- R10: `mem_tag` is 0 after reset and inverts on every branch. Every request carries the current value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| br_valid | input | 1 | Branch: flush and restart at `br_addr` |
| br_addr | input | ADDR_W | Branch target byte address |
| ins_valid | output | 1 | An instruction is offered to the core |
| ins_ready | input | 1 | The core accepts the offered instruction |
| ins_data | output | 32 | Realigned instruction |
| ins_pc | output | ADDR_W | Byte address of the offered instruction |
| mem_req | output | 1 | Fetch request |
| mem_gnt | input | 1 | Memory accepts the request this cycle |
| mem_addr | output | ADDR_W-2 | Word address of the request |
| mem_tag | output | 1 | Epoch tag sent with the request |
| mem_rvalid | input | 1 | Response word present |
| mem_rtag | input | 1 | Epoch tag returned with the response |
| mem_rdata | input | 32 | Response word |

## Verification
The case that matters most is a branch in the same cycle as a memory response, as a delivery handshake, or both. The bench gives each response the branch generation at which it was requested. It drives branches at random times while responses are still arriving with random gaps, and it adds back-to-back branches and short backward branches. A stale word that slips through shows up as a wrong instruction word against the computed memory image. A handshake during a branch shows up as a request or valid seen in the branch cycle. A word counted twice or lost shows up as a wrong `ins_pc` sequence.

// File: rtl/ifq_pkg.sv
// Shared types for the streaming instruction fetch queue.
// Assumes 32-bit instructions and 32-bit memory words.
package ifq_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned WORD_BYTES = WORD_W / 8;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ifq_word_buf.sv
// Circular word store with a count.
// Exposes the head word and the word after it, so the aligner can build an instruction
// that spans two words. A flush empties it in one cycle.
// Assumes DEPTH is a power of two, so the pointers wrap by overflow.
module ifq_word_buf
    import ifq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             push,
    input  word_t            push_data,
    input  logic             pop,
    output word_t            head0,
    output word_t            head1,
    output logic [CNT_W-1:0] count
);
    word_t            store [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;

    // Write an arriving word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push && !flush) store[wr_ptr] <= push_data;
    end

    // Move the pointers and the count; a flush empties the store.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            count <= count + CNT_W'(push) - CNT_W'(pop);
        end
    end

    assign head0 = store[rd_ptr];
    assign head1 = store[rd_ptr + PTR_W'(1)];

    // R4
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !flush) |-> (32'(count) < DEPTH || pop));
endmodule

// File: rtl/ifq_fetch_ctl.sv
// Fetch control.
// Issues sequential word requests from the branch target while buffered words plus
// pending requests stay below DEPTH. It keeps the epoch tag and tells live responses
// from stale ones.
// Assumes in-order responses: once a branch happens, the next `stale` responses
// belong to earlier epochs.
module ifq_fetch_ctl #(
    parameter int ADDR_W   = 20,
    parameter int DEPTH    = 8,
    parameter int MAX_INFL = 15,
    localparam int WADDR_W = ADDR_W - 2,
    localparam int CNT_W   = $clog2(DEPTH + 1),
    localparam int INFL_W  = $clog2(MAX_INFL + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_valid,
    input  logic [ADDR_W-1:0]  br_addr,
    input  logic [CNT_W-1:0]   buf_count,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic [WADDR_W-1:0] mem_addr,
    output logic               mem_tag,
    input  logic               mem_rvalid,
    input  logic               mem_rtag,
    output logic               resp_live
);
    logic               active, epoch;
    logic [WADDR_W-1:0] fa;
    logic [INFL_W-1:0]  pend, stale;
    logic               has_room, infl_ok, issue, resp_cur, resp_stale;

    // Decide whether a request may go out and how a response is classed.
    always_comb begin
        has_room   = (32'(pend) + 32'(buf_count)) < 32'(DEPTH);
        infl_ok    = (32'(pend) + 32'(stale)) < 32'(MAX_INFL);
        mem_req    = active && !br_valid && has_room && infl_ok;
        issue      = mem_req && mem_gnt;
        resp_stale = mem_rvalid && (stale != '0);
        resp_cur   = mem_rvalid && (stale == '0);
        resp_live  = resp_cur && !br_valid && (mem_rtag == epoch);
    end

    // Track the fetch address, the epoch and the pending/stale response counts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            epoch  <= 1'b0;
            fa     <= '0;
            pend   <= '0;
            stale  <= '0;
        end else if (br_valid) begin
            active <= 1'b1;
            epoch  <= ~epoch;
            fa     <= br_addr[ADDR_W-1:2];
            pend   <= '0;
            stale  <= stale + pend - INFL_W'(mem_rvalid);
        end else begin
            if (issue) fa <= fa + WADDR_W'(1);
            pend  <= pend + INFL_W'(issue) - INFL_W'(resp_cur);
            stale <= stale - INFL_W'(resp_stale);
        end
    end

    assign mem_addr = fa;
    assign mem_tag  = epoch;

    // R2
    req_seq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |=> (br_valid || mem_addr == $past(mem_addr) + WADDR_W'(1)));
    // R7
    live_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rvalid && stale == '0 && !br_valid) |-> (mem_rtag == epoch));
    // R10
    epoch_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        br_valid |=> (mem_tag != $past(mem_tag)));
endmodule

// File: rtl/ifq_byte_align.sv
// Byte realignment.
// Builds a 32-bit instruction from the head word and the word after it, given the
// byte offset. It reports whether enough words are buffered for that offset.
module ifq_byte_align
    import ifq_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  word_t            head0,
    input  word_t            head1,
    input  logic [CNT_W-1:0] count,
    input  logic [1:0]       offset,
    output logic             avail,
    output word_t            ins
);
    logic [2*WORD_W-1:0] pair, shifted;

    // Shift the two-word window down by the byte offset; little-endian byte order.
    always_comb begin
        pair    = {head1, head0};
        shifted = pair >> {offset, 3'b000};
        ins     = shifted[WORD_W-1:0];
        avail   = (offset == 2'b00) ? (count >= CNT_W'(1)) : (count >= CNT_W'(2));
    end
endmodule

// File: rtl/ifq_stream_fetch.sv
// Streaming instruction fetch queue, top level.
// A branch flushes the buffer and restarts fetching at a byte address. Words fill an
// 8-entry (DEPTH) buffer; instructions leave realigned, one per accepted handshake.
// Assumes the memory answers in grant order. Each accepted instruction pops exactly
// one word, because the byte offset stays the same from one instruction to the next.
module ifq_stream_fetch
    import ifq_pkg::*;
#(
    parameter int ADDR_W   = 20,
    parameter int DEPTH    = 8,
    parameter int MAX_INFL = 15,
    localparam int WADDR_W = ADDR_W - 2,
    localparam int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               br_valid,
    input  logic [ADDR_W-1:0]  br_addr,
    output logic               ins_valid,
    input  logic               ins_ready,
    output logic [31:0]        ins_data,
    output logic [ADDR_W-1:0]  ins_pc,
    output logic               mem_req,
    input  logic               mem_gnt,
    output logic [WADDR_W-1:0] mem_addr,
    output logic               mem_tag,
    input  logic               mem_rvalid,
    input  logic               mem_rtag,
    input  logic [31:0]        mem_rdata
);
    logic             resp_live, avail, pop;
    logic [CNT_W-1:0] count;
    word_t            head0, head1, aligned;
    logic [ADDR_W-1:0] pc;

    ifq_fetch_ctl #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .MAX_INFL(MAX_INFL)) u_ctl (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_addr(br_addr),
        .buf_count(count), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_tag(mem_tag), .mem_rvalid(mem_rvalid),
        .mem_rtag(mem_rtag), .resp_live(resp_live)
    );

    ifq_word_buf #(.DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n), .flush(br_valid), .push(resp_live),
        .push_data(mem_rdata), .pop(pop), .head0(head0), .head1(head1),
        .count(count)
    );

    ifq_byte_align #(.DEPTH(DEPTH)) u_align (
        .head0(head0), .head1(head1), .count(count), .offset(pc[1:0]),
        .avail(avail), .ins(aligned)
    );

    // Offer an instruction unless a branch is flushing in this cycle.
    always_comb begin
        ins_valid = avail && !br_valid;
        pop       = ins_valid && ins_ready;
    end

    // Keep the byte address of the instruction at the head of the stream.
    always_ff @(posedge clk) begin
        if (!rst_n)        pc <= '0;
        else if (br_valid) pc <= br_addr;
        else if (pop)      pc <= pc + ADDR_W'(WORD_BYTES);
    end

    assign ins_data = aligned;
    assign ins_pc   = pc;

    // R5
    pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_valid && ins_ready) |=> (br_valid || ins_pc == $past(ins_pc) + ADDR_W'(4)));
    // R6
    need_words_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |-> (count >= ((ins_pc[1:0] == 2'b00) ? CNT_W'(1) : CNT_W'(2))));
endmodule

// File: tb/sim_ifq_stream_fetch.sv
`timescale 1ns/1ps
module sim_ifq_stream_fetch;
    localparam int ADDR_W = 20;
    localparam int DEPTH  = 8;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic br_valid = 1'b0;
    logic [ADDR_W-1:0] br_addr = '0;
    logic ins_valid, ins_ready = 1'b0;
    logic [31:0] ins_data;
    logic [ADDR_W-1:0] ins_pc;
    logic mem_req, mem_gnt = 1'b0, mem_tag;
    logic [ADDR_W-3:0] mem_addr;
    logic mem_rvalid = 1'b0, mem_rtag = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    ifq_stream_fetch #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .br_addr(br_addr),
        .ins_valid(ins_valid), .ins_ready(ins_ready), .ins_data(ins_data),
        .ins_pc(ins_pc), .mem_req(mem_req), .mem_gnt(mem_gnt),
        .mem_addr(mem_addr), .mem_tag(mem_tag), .mem_rvalid(mem_rvalid),
        .mem_rtag(mem_rtag), .mem_rdata(mem_rdata)
    );

    typedef struct {
        int                due;
        logic [ADDR_W-3:0] a;
        logic              t;
        int                g;
    } rsp_t;

    rsp_t q[$];
    int n_chk = 0, n_bad = 0, cyc = 0, gen = 0, cur_g = -1;
    int live_words = 0, issued_br = 0, gaps = 0;
    bit first_valid_seen = 0, started = 0, done = 0;
    logic [ADDR_W-3:0] exp_fa = '0;
    logic [ADDR_W-1:0] exp_pc = '0;
    logic exp_tag = 1'b0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    function automatic logic [31:0] mw(input logic [ADDR_W-3:0] a);
        logic [31:0] x;
        x = {14'h0, a} * 32'h9E37_79B1;
        return x ^ {a[7:0], a[17:10], 16'h5A3C};
    endfunction

    // Little-endian instruction starting at byte address p (R5).
    function automatic logic [31:0] ins_at(input logic [ADDR_W-1:0] p);
        logic [31:0] r;
        logic [ADDR_W-1:0] b;
        logic [31:0] w;
        for (int i = 0; i < 4; i++) begin
            b = p + ADDR_W'(i);
            w = mw(b[ADDR_W-1:2]);
            r[8*i +: 8] = w[8*b[1:0] +: 8];
        end
        return r;
    endfunction

    task automatic step(input bit br, input logic [ADDR_W-1:0] ba, input bit rdy,
                        input bit gnt, input bit rsp_ok);
        rsp_t r;
        @(negedge clk);
        cyc++;
        if (rsp_ok && q.size() > 0 && q[0].due <= cyc) begin
            r = q.pop_front();
            mem_rvalid = 1'b1;
            mem_rdata  = mw(r.a);
            mem_rtag   = r.t;
            cur_g      = r.g;
        end else begin
            mem_rvalid = 1'b0;
            cur_g      = -1;
        end
        br_valid  = br;
        br_addr   = ba;
        ins_ready = rdy;
        mem_gnt   = gnt;
        #1;
        if (!started && rst_n)
            chk(!ins_valid && !mem_req, "R1 idle before first branch", {30'd0, ins_valid, mem_req}, 32'd0);
        if (br) begin
            chk(!ins_valid && !mem_req, "R8 quiet in branch cycle", {30'd0, ins_valid, mem_req}, 32'd0);
            gen++;
            exp_pc = ba;
            exp_fa = ba[ADDR_W-1:2];
            exp_tag = ~exp_tag;
            live_words = 0;
            issued_br = 0;
            first_valid_seen = 0;
            started = 1;
        end
        if (first_valid_seen && !ins_valid && !br) gaps++;
        if (ins_valid) begin
            if (!first_valid_seen) begin
                chk(live_words >= ((exp_pc[1:0] != 2'b00) ? 2 : 1), "R6 words before first valid",
                    32'(live_words), (exp_pc[1:0] != 2'b00) ? 32'd2 : 32'd1);
                first_valid_seen = 1;
            end
            if (ins_ready) begin
                chk(ins_pc == exp_pc, "R5 pc", 32'(ins_pc), 32'(exp_pc));
                chk(ins_data == ins_at(exp_pc), "R5 R7 data", ins_data, ins_at(exp_pc));
                exp_pc = exp_pc + ADDR_W'(4);
            end
        end
        if (mem_req && mem_gnt) begin
            chk(mem_addr == exp_fa, "R2/R9 request address", 32'(mem_addr), 32'(exp_fa));
            chk(mem_tag == exp_tag, "R10 request tag", 32'(mem_tag), 32'(exp_tag));
            r.due = cyc + LAT; r.a = mem_addr; r.t = mem_tag; r.g = gen;
            q.push_back(r);
            exp_fa = exp_fa + 1'b1;
            issued_br++;
        end
        if (mem_rvalid && cur_g == gen) live_words++;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // Reset and idle (R1).
        repeat (4) step(0, '0, 1, 1, 1);
        rst_n = 1'b1;
        repeat (5) step(0, '0, 1, 1, 1);
        chk(mem_tag == 1'b0, "R10 reset tag", 32'(mem_tag), 32'd0);

        // Stalled core: DEPTH requests back to back, then a stop (R3, R4).
        step(1, 20'h00100, 0, 1, 1);
        repeat (DEPTH) step(0, '0, 0, 1, 1);
        chk(issued_br == DEPTH, "R3 back-to-back requests", 32'(issued_br), 32'(DEPTH));
        repeat (30) step(0, '0, 0, 1, 1);
        chk(issued_br == DEPTH, "R4 stop when full", 32'(issued_br), 32'(DEPTH));
        step(0, '0, 1, 1, 1);
        repeat (6) step(0, '0, 0, 1, 1);
        chk(issued_br == DEPTH + 1, "R4 one resume per pop", 32'(issued_br), 32'(DEPTH + 1));

        // Branch to a buffered word: fresh requests from the target (R9).
        step(1, 20'h0010C, 0, 1, 1);
        step(0, '0, 0, 1, 1);
        chk(issued_br == 1, "R9 refetch of buffered target", 32'(issued_br), 32'd1);
        repeat (10) step(0, '0, 1, 1, 1);

        // Full-rate streaming from each byte offset (R3, R5, R6).
        for (int k = 0; k < 4; k++) begin
            step(1, 20'h00200 + 20'(k * 'h101), 1, 1, 1);
            gaps = 0;
            repeat (40) step(0, '0, 1, 1, 1);
            chk(gaps == 0, "R3 full-rate delivery", 32'(gaps), 32'd0);
        end

        // Short backward branch, then branches on top of responses in flight (R7, R9).
        step(1, exp_pc - 20'd8, 1, 1, 1);
        repeat (3) step(0, '0, 1, 1, 1);
        step(1, 20'h4_0003, 1, 1, 1);
        step(1, 20'h0_8002, 1, 1, 1);
        step(0, '0, 1, 1, 1);
        step(1, 20'h1_2345, 1, 1, 1);
        repeat (30) step(0, '0, 1, 1, 1);
        chk(first_valid_seen, "R7 stream resumes after stacked branches", 32'(first_valid_seen), 32'd1);

        // Random traffic.
        for (int i = 0; i < 5000; i++) begin
            bit br;
            logic [ADDR_W-1:0] ba;
            br = ($urandom % 40) == 0;
            if ($urandom % 2) ba = exp_pc - ADDR_W'(($urandom % 6) * 4 + ($urandom % 4));
            else              ba = ADDR_W'($urandom);
            step(br, ba, ($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 5) != 0);
        end
        repeat (20) step(0, '0, 1, 1, 1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule